// File: doc/BRIEF.md
# Cascaded Interval Timer Unit

This block provides three down-counting interval timers for a sound controller. A free-standing 16-bit timer (timer 0) steps once per tick. A 12-bit prescaler also steps once per tick, and each time it runs out it produces one step for two chained timers: a 4-bit timer (timer 1) and a 16-bit timer (timer 2). The `tick` clock-enable supplies one timer step. The system is expected to pulse it once every 32 input clocks times a fixed divider.

Software sets the timers through byte-wide reload registers and a control register. A counter reloads only when it runs out. Each expiry latches a flag. One read strobe returns the flags and clears them. The interrupt line is high while any flag is set whose mask bit is clear.

Register map (`wr_addr`): 0 = timer 0 reload low byte, 1 = timer 0 reload high byte, 2 = prescaler reload bits 7:0, 3 = chained register, 4 = timer 2 reload low byte, 5 = timer 2 reload high byte, 6 = control. In the chained register, bits 7:4 hold the timer 1 reload and bits 3:0 hold prescaler reload bits 11:8. Control bits: 0 runs timer 0, 1 runs timer 1, 2 runs timer 2, 3 runs the prescaler, 4/5/6 mask the interrupts of timers 0/1/2. Address 7 is ignored.

Top module: `cascade_timers`

## Requirements
- R1: While control bit 0 is set, timer 0 decrements on each tick. When it reaches zero it reloads from {addr 1, addr 0} and sets status bit 4.
- R2: While control bit 3 is set, the prescaler decrements on each tick. On reaching zero it expires and reloads from {addr 3 bits 3:0, addr 2}.
- R3: Timer 1 steps only on a prescaler expiry while control bit 1 is set. On reaching zero it reloads from addr 3 bits 7:4 and sets status bit 5.
- R4: Timer 2 steps only on a prescaler expiry while control bit 2 is set. On reaching zero it reloads from {addr 5, addr 4} and sets status bit 6.
- R5: A counter holding zero wraps to its all-ones value on its next step, so a zero count or reload gives a full period: 65536 steps for the 16-bit timers, 4096 for the prescaler and 16 for timer 1.
- R6: A timer whose run bit is clear keeps its count and raises no flag.
- R7: `rd_data` shows the flags in bits 6:4 and zero in the other bits. A cycle with `rd_stb` high clears all flags. An expiry in that same cycle still leaves its flag set.
- R8: `irq` is high exactly when some status flag is set and the matching mask bit (control bit 4, 5 or 6) is 0.
- R9: After reset all counters, reload registers, control bits and flags are zero, `rd_data` is 0 and `irq` is low.
- R10: Without `tick` no counter changes and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer step enable, one step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| rd_stb | input | 1 | Status read strobe; clears the flags |
| rd_data | output | 8 | Status flags in bits 6:4 |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach is a timer 2 expiry. Timer 2 leaves reset at zero, so its first expiry needs 65536 prescaler expiries, and the prescaler's own first run lasts 4096 ticks. The stimulus sets the prescaler reload to 1 so that it expires on every tick after its first period. It then holds `tick` high for about 70,000 cycles, reading the status at the exact ticks where timer 1 and timer 2 should expire. A read that lands in the same cycle as a timer 0 expiry is also placed deliberately, to show that the set wins over the clear.

// File: rtl/cascade_timers_pkg.sv
package cascade_timers_pkg;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 8;
    localparam int T0_W       = 16;
    localparam int PRE_W      = 12;
    localparam int T1_W       = 4;
    localparam int T2_W       = 16;
    localparam int NUM_TMR    = 3;
    localparam int CTRL_W     = 7;
    localparam int NUM_RLD    = 6;
    localparam int FLAG_LSB   = 4;

    localparam logic [ADDR_W-1:0] A_T0_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_T0_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_PRE   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CHAIN = 3'd3;
    localparam logic [ADDR_W-1:0] A_T2_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_T2_HI = 3'd5;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd6;

    localparam int C_RUN0  = 0;
    localparam int C_RUN1  = 1;
    localparam int C_RUN2  = 2;
    localparam int C_RUNP  = 3;
    localparam int C_MASK0 = 4;
endpackage

// File: rtl/ct_down_counter.sv
module ct_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] reload_val,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_dec;

    assign cnt_dec = cnt_q - 1'b1;
    assign expire  = step && (cnt_q == W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (cnt_dec == '0) ? reload_val : cnt_dec;
        end
    end
endmodule

// File: rtl/ct_cfg_regs.sv
module ct_cfg_regs
    import cascade_timers_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [T0_W-1:0]   t0_rld,
    output logic [PRE_W-1:0]  pre_rld,
    output logic [T1_W-1:0]   t1_rld,
    output logic [T2_W-1:0]   t2_rld,
    output logic [CTRL_W-1:0] ctrl
);
    logic [DATA_W-1:0] rld_q [NUM_RLD];
    logic [CTRL_W-1:0] ctrl_q;

    for (genvar i = 0; i < NUM_RLD; i++) begin : g_rld
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rld_q[i] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
                rld_q[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && (wr_addr == A_CTRL)) begin
            ctrl_q <= wr_data[CTRL_W-1:0];
        end
    end

    assign t0_rld  = {rld_q[A_T0_HI], rld_q[A_T0_LO]};
    assign pre_rld = {rld_q[A_CHAIN][3:0], rld_q[A_PRE]};
    assign t1_rld  = rld_q[A_CHAIN][7:4];
    assign t2_rld  = {rld_q[A_T2_HI], rld_q[A_T2_LO]};
    assign ctrl    = ctrl_q;
endmodule

// File: rtl/ct_status.sv
module ct_status
    import cascade_timers_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] expire,
    input  logic               rd_stb,
    input  logic [NUM_TMR-1:0] mask,
    output logic [NUM_TMR-1:0] flags,
    output logic               irq
);
    logic [NUM_TMR-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (rd_stb ? '0 : flags_q) | expire;
        end
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & ~mask);
endmodule

// File: rtl/cascade_timers.sv
module cascade_timers
    import cascade_timers_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int PAD_HI = DATA_W - FLAG_LSB - NUM_TMR;

    logic [T0_W-1:0]    t0_rld;
    logic [PRE_W-1:0]   pre_rld;
    logic [T1_W-1:0]    t1_rld;
    logic [T2_W-1:0]    t2_rld;
    logic [CTRL_W-1:0]  ctrl_q;
    logic               t0_exp, pre_exp, t1_exp, t2_exp;
    logic [NUM_TMR-1:0] flags_q;

    ct_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .t0_rld(t0_rld), .pre_rld(pre_rld), .t1_rld(t1_rld), .t2_rld(t2_rld), .ctrl(ctrl_q)
    );

    ct_down_counter #(.W(T0_W)) u_t0 (
        .clk(clk), .rst_n(rst_n), .step(tick && ctrl_q[C_RUN0]),
        .reload_val(t0_rld), .expire(t0_exp)
    );

    ct_down_counter #(.W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .step(tick && ctrl_q[C_RUNP]),
        .reload_val(pre_rld), .expire(pre_exp)
    );

    ct_down_counter #(.W(T1_W)) u_t1 (
        .clk(clk), .rst_n(rst_n), .step(pre_exp && ctrl_q[C_RUN1]),
        .reload_val(t1_rld), .expire(t1_exp)
    );

    ct_down_counter #(.W(T2_W)) u_t2 (
        .clk(clk), .rst_n(rst_n), .step(pre_exp && ctrl_q[C_RUN2]),
        .reload_val(t2_rld), .expire(t2_exp)
    );

    ct_status u_stat (
        .clk(clk), .rst_n(rst_n), .expire({t2_exp, t1_exp, t0_exp}), .rd_stb(rd_stb),
        .mask(ctrl_q[C_MASK0 +: NUM_TMR]), .flags(flags_q), .irq(irq)
    );

    assign rd_data = {{PAD_HI{1'b0}}, flags_q, {FLAG_LSB{1'b0}}};
endmodule

// File: rtl/cascade_timers_checker.sv
module cascade_timers_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       rd_stb,
    input logic [6:0] ctrl,
    input logic [2:0] flags,
    input logic       t0_exp,
    input logic       pre_exp,
    input logic       t1_exp,
    input logic       t2_exp,
    input logic       irq
);
    assert_t0_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        t0_exp |=> flags[0]);

    assert_t1_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        t1_exp |-> (pre_exp && ctrl[1]));

    assert_t2_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        t2_exp |-> (pre_exp && ctrl[2]));

    assert_t0_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] |-> !t0_exp);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !t0_exp && !t1_exp && !t2_exp) |=> (flags == 3'b000));

    assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && flags[1]) |=> flags[1]);

    assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags == 3'b000) || (ctrl[6:4] == 3'b111)) |-> !irq);

    assert_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> !(t0_exp || pre_exp));
endmodule

bind cascade_timers cascade_timers_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rd_stb(rd_stb), .ctrl(ctrl_q),
    .flags(flags_q), .t0_exp(t0_exp), .pre_exp(pre_exp), .t1_exp(t1_exp),
    .t2_exp(t2_exp), .irq(irq)
);

// File: tb/cascade_timers_bench.sv
module cascade_timers_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    cascade_timers u_cascade_timers (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
    );

    // Stage-2 table: ticks to run, bits compared, expected bits, read afterwards
    localparam int          NVEC = 6;
    localparam int          VEC_TICKS [NVEC] = '{4110, 1, 3, 65516, 1, 2};
    localparam logic [7:0]  VEC_CARE  [NVEC] = '{8'h70, 8'h70, 8'h70, 8'h40, 8'h40, 8'h40};
    localparam logic [7:0]  VEC_EXP   [NVEC] = '{8'h00, 8'h20, 8'h20, 8'h00, 8'h40, 8'h40};
    localparam bit          VEC_RD    [NVEC] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk);
        rd_stb = 1'b1;
        v = rd_data;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data == 8'h00, "R9 status after reset", rd_data, 0);
        chk(irq == 1'b0, "R9 irq after reset", irq, 0);

        wr(3'd0, 8'h03); wr(3'd1, 8'h00);
        wr(3'd2, 8'h01); wr(3'd3, 8'h30);
        wr(3'd4, 8'h02); wr(3'd5, 8'h00);
        wr(3'd6, 8'h71);

        // Stage 1: timer 0, counter starts at zero
        run(65535);
        chk(rd_data == 8'h00, "R5 timer0 no expiry before 65536", rd_data, 0);
        run(1);
        chk(rd_data == 8'h10, "R1 timer0 flag at 65536", rd_data, 8'h10);
        chk(irq == 1'b0, "R8 masked timer0 irq", irq, 0);
        wr(3'd6, 8'h61);
        chk(irq == 1'b1, "R8 unmasked timer0 irq", irq, 1);
        rd(v);
        chk(v == 8'h10, "R7 read returns flag", v, 8'h10);
        chk(rd_data == 8'h00, "R7 read clears", rd_data, 0);
        chk(irq == 1'b0, "R8 irq drops after clear", irq, 0);
        run(2);
        chk(rd_data == 8'h00, "R1 reload 3 not yet expired", rd_data, 0);
        repeat (20) @(negedge clk);
        chk(rd_data == 8'h00, "R10 idle without tick", rd_data, 0);
        tick = 1'b1; rd_stb = 1'b1;
        @(negedge clk);
        tick = 1'b0; rd_stb = 1'b0;
        chk(rd_data == 8'h10, "R7 expiry wins over read clear", rd_data, 8'h10);
        rd(v);
        wr(3'd6, 8'h0E);

        // Stage 2: prescaler with timers 1 and 2, timer 0 stopped
        for (int i = 0; i < NVEC; i++) begin
            run(VEC_TICKS[i]);
            chk((rd_data & VEC_CARE[i]) == VEC_EXP[i], "R2 R3 R4 R6 chained vector",
                rd_data & VEC_CARE[i], VEC_EXP[i]);
            if (VEC_EXP[i] != 8'h00)
                chk(irq == 1'b1, "R8 chained irq", irq, 1);
            if (VEC_RD[i]) begin
                rd(v);
                chk(rd_data == 8'h00, "R7 clear after chained read", rd_data, 0);
            end
        end

        wr(3'd6, 8'h6E);
        run(3);
        chk(rd_data == 8'h60, "R3 R4 both chained flags", rd_data, 8'h60);
        chk(irq == 1'b0, "R8 masked chained irq", irq, 0);
        wr(3'd6, 8'h4E);
        chk(irq == 1'b1, "R8 timer1 unmasked", irq, 1);

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(rd_data == 8'h00, "R9 status after second reset", rd_data, 0);
        chk(irq == 1'b0, "R9 irq after second reset", irq, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule